// File: doc/BRIEF.md
# DDR3 Timing Calculator

This block turns DDR3 device timings into controller cycle counts. It takes a requested data rate in MT/s, a flag selecting the high-end or the standard device family, a density code in Gb, a page-size flag, and three row timings (tRCmin, tRASmin, tRCD) in units of 10 ps. On a start pulse it registers these inputs. It then caps the data rate for the family and derives the memory clock in MHz and the clock period in picoseconds. After that it works out each timing field by dividing a time by the period, rounding up.

The quotients all come from one restoring divider, which produces one quotient bit per clock. The parameters are evaluated in a fixed sequence. Most results are stored as the cycle count minus one. A done flag goes high once the whole set is valid. An error flag replaces the results when the density or the capped speed is not supported.

Top module: `ddr3_timing_calc`

## Requirements
- R1: While reset is asserted and after it, until the first start, done_o, busy_o and err_o are 0, and every result output, including cwl_o, is 0.
- R2: For the high-end family (fam_hi_i=1), the rate is capped at 1066 and cwl_o is 4. For the standard family, the rate is capped at 800 and cwl_o is 3. The clock in MHz is half the capped rate, limited to 528 for the high-end family.
- R3: clkper_o is the integer quotient of 1,000,000 divided by the clock in MHz. That gives 1893 at 1066 and 2500 at 800.
- R4: The density code (dens_i) must be 1, 2, 4 or 8 Gb, which selects a refresh time of 110, 160, 260 or 350 ns. trfc_o is ceil(tRFC/period)-1. txs_o uses tRFC plus 10 ns in the same way.
- R5: txp_o is ceil(max(3 clocks, 7.5 ns))-1. txpdll_o is ceil(max(10 clocks, 24 ns))-1. tmrd_o is ceil(max(12 clocks, 15 ns))-1. tcksre_o is ceil(max(5 clocks, 10 ns)) with nothing subtracted.
- R6: At 1066, tcke_o uses max(3 clocks, 5.625 ns). With page_i=1, tfaw_o uses 37.5 ns and trrd_o uses max(4 clocks, 7.5 ns); with page_i=0 they use 50 ns and max(4 clocks, 10 ns). At 800, tcke_o uses max(3 clocks, 7.5 ns), tfaw_o uses 40 ns (page_i=1) or 50 ns, and trrd_o uses max(4 clocks, 10 ns). All of these are stored as ceiling minus 1.
- R7: twr_o is ceil(15 ns/period)-1 and taonpd_o is ceil(2 ns/period)-1.
- R8: With p10 = floor(period/10), trc_o = ceil(tRC/p10)-1 and tras_o = ceil(tRAS/p10)-1. tcl_o = ceil(tRCD/p10)-3 and trp_o = ceil(tRCD/p10)-1. All are modulo 2^16.
- R9: An unsupported density, or a capped rate other than 800 or 1066, raises done_o and err_o on the clock after the start is accepted, with every result output and cwl_o at 0.
- R10: After done_o rises, it and all outputs hold until the next accepted start, whatever the data inputs do. A start pulse while busy_o is high is ignored.
- R11: For a valid request, busy_o is high and done_o is low from the clock after the start is accepted until done_o rises. With default parameters, done_o rises 391 clocks after the start edge (17 steps of 23 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted when not busy |
| rate_i | input | 16 | Requested data rate, MT/s |
| fam_hi_i | input | 1 | 1 = high-end family, 0 = standard family |
| dens_i | input | 4 | Device density in Gb (1, 2, 4, 8) |
| page_i | input | 1 | Page-size flag |
| trc_i | input | 16 | tRCmin, 10 ps units |
| tras_i | input | 16 | tRASmin, 10 ps units |
| trcd_i | input | 16 | tRCD, 10 ps units |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Results (or error) valid |
| err_o | output | 1 | Unsupported density or speed |
| cwl_o | output | 3 | CAS write latency |
| clkper_o | output | 16 | Clock period, ps |
| trfc_o | output | 16 | Refresh cycle count |
| txs_o | output | 16 | Self-refresh exit count |
| txp_o | output | 16 | Power-down exit count |
| tcke_o | output | 16 | CKE minimum pulse count |
| tfaw_o | output | 16 | Four-activate window count |
| trrd_o | output | 16 | Activate-to-activate count |
| txpdll_o | output | 16 | Exit with DLL count |
| tcksre_o | output | 16 | Clock hold after self-refresh entry |
| taonpd_o | output | 16 | ODT turn-on in power-down count |
| twr_o | output | 16 | Write recovery count |
| tmrd_o | output | 16 | Mode register set count |
| trc_o | output | 16 | Row cycle count |
| tras_o | output | 16 | Row active count |
| tcl_o | output | 16 | CAS latency field |
| trp_o | output | 16 | Precharge count |

## Verification
Requests cover both families at both supported speeds. The set includes rates above each cap, so capping and the 528 MHz limit are exercised. The 1893 ps period shows up ceiling-rounding slips that the round 2500 ps period hides. Each speed is run with both page flags and with all four densities, which separates the choice of time constant from the choice of clock floor.

Error requests (a bad density, a bad high-end rate, a bad standard rate) are each followed by a valid run, to show recovery. A start pulse during a run and input changes while done_o is high show that the captured values stay in use.

// File: rtl/ddr3_calc_pkg.sv
package ddr3_calc_pkg;
  localparam int RATE_HI    = 1066;
  localparam int RATE_LO    = 800;
  localparam int CLK_HI_MAX = 528;
  localparam int CWL_HI     = 4;
  localparam int CWL_LO     = 3;
  localparam int CKW        = 10;
  localparam int PS_MHZ     = 1000000;
  localparam int NSTEP      = 17;

  typedef enum logic [4:0] {
    ST_PER, ST_P10, ST_RFC, ST_XS, ST_XP, ST_CKE, ST_FAW, ST_RRD, ST_XPDLL,
    ST_CKSRE, ST_AONPD, ST_WR, ST_MRD, ST_RC, ST_RAS, ST_CL, ST_RP
  } step_e;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} fsm_e;

  function automatic int rfc_ps(input logic [3:0] d);
    case (d)
      4'd1:    return 110000;
      4'd2:    return 160000;
      4'd4:    return 260000;
      4'd8:    return 350000;
      default: return 0;
    endcase
  endfunction

  function automatic logic dens_ok(input logic [3:0] d);
    return (d == 4'd1) || (d == 4'd2) || (d == 4'd4) || (d == 4'd8);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ddr3_clk_sel.sv
module ddr3_clk_sel
  import ddr3_calc_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic [RW-1:0]  rate_i,
  input  logic           fam_hi_i,
  output logic [CKW-1:0] clk_mhz_o,
  output logic [2:0]     cwl_o,
  output logic           fast_o,
  output logic           bad_o
);
  logic [RW-1:0] cap;
  logic [RW-1:0] half;

  always_comb begin
    if (fam_hi_i) cap = (rate_i > RW'(RATE_HI)) ? RW'(RATE_HI) : rate_i;
    else          cap = (rate_i > RW'(RATE_LO)) ? RW'(RATE_LO) : rate_i;
    half   = cap >> 1;
    fast_o = (cap == RW'(RATE_HI));
    bad_o  = !((cap == RW'(RATE_LO)) || fast_o);
    cwl_o  = fam_hi_i ? 3'(CWL_HI) : 3'(CWL_LO);
    if (fam_hi_i && (half > RW'(CLK_HI_MAX))) clk_mhz_o = CKW'(CLK_HI_MAX);
    else                                      clk_mhz_o = CKW'(half);
  end
endmodule

// File: rtl/ddr3_step_gen.sv
module ddr3_step_gen
  import ddr3_calc_pkg::*;
#(
  parameter int DW = 20,
  parameter int BW = 16,
  parameter int W  = 16,
  parameter int TW = 16
) (
  input  step_e          step_i,
  input  logic [CKW-1:0] clk_mhz_i,
  input  logic [W-1:0]   per_i,
  input  logic [W-1:0]   per10_i,
  input  logic           fast_i,
  input  logic           page_i,
  input  logic [3:0]     dens_i,
  input  logic [TW-1:0]  trc_i,
  input  logic [TW-1:0]  tras_i,
  input  logic [TW-1:0]  trcd_i,
  output logic [DW-1:0]  num_o,
  output logic [BW-1:0]  den_o,
  output logic           ceil_o,
  output logic [1:0]     sub_o
);
  int p, num_v, den_v;

  always_comb begin
    p      = int'(per_i);
    den_v  = p;
    ceil_o = 1'b1;
    sub_o  = 2'd1;
    num_v  = 0;
    case (step_i)
      ST_PER:   begin num_v = PS_MHZ; den_v = int'(clk_mhz_i); ceil_o = 1'b0; sub_o = 2'd0; end
      ST_P10:   begin num_v = p; den_v = 10; ceil_o = 1'b0; sub_o = 2'd0; end
      ST_RFC:   num_v = rfc_ps(dens_i);
      ST_XS:    num_v = rfc_ps(dens_i) + 10000;
      ST_XP:    num_v = imax(3 * p, 7500);
      ST_CKE:   num_v = imax(3 * p, fast_i ? 5625 : 7500);
      ST_FAW:   num_v = page_i ? (fast_i ? 37500 : 40000) : 50000;
      ST_RRD:   num_v = imax(4 * p, (fast_i && page_i) ? 7500 : 10000);
      ST_XPDLL: num_v = imax(10 * p, 24000);
      ST_CKSRE: begin num_v = imax(5 * p, 10000); sub_o = 2'd0; end
      ST_AONPD: num_v = 2000;
      ST_WR:    num_v = 15000;
      ST_MRD:   num_v = imax(12 * p, 15000);
      ST_RC:    begin num_v = int'(trc_i);  den_v = int'(per10_i); end
      ST_RAS:   begin num_v = int'(tras_i); den_v = int'(per10_i); end
      ST_CL:    begin num_v = int'(trcd_i); den_v = int'(per10_i); sub_o = 2'd3; end
      ST_RP:    begin num_v = int'(trcd_i); den_v = int'(per10_i); end
      default:  num_v = 0;
    endcase
    num_o = DW'(num_v);
    den_o = BW'(den_v);
  end
endmodule

// File: rtl/ddr3_ceil_div.sv
module ddr3_ceil_div #(
  parameter int DW = 20,
  parameter int BW = 16,
  parameter int QW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ceil_i,
  input  logic [DW-1:0] num_i,
  input  logic [BW-1:0] den_i,
  output logic          done_o,
  output logic [QW-1:0] quot_o
);
  localparam int NW = DW + 1;
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] num_q;
  logic [BW-1:0] den_q, rem_q, rem_nx;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [BW:0]   shifted, diff;
  logic          ge;

  always_comb begin
    shifted = {rem_q, num_q[NW-1]};
    ge      = shifted >= {1'b0, den_q};
    diff    = shifted - {1'b0, den_q};
    rem_nx  = ge ? diff[BW-1:0] : shifted[BW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        // ceiling as floor of (a + b - 1) / b
        num_q  <= ceil_i ? (NW'(num_i) + NW'(den_i) - NW'(1)) : NW'(num_i);
        den_q  <= den_i;
        rem_q  <= '0;
        cnt_q  <= CW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nx;
        num_q <= {num_q[NW-2:0], ge};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = num_q[QW-1:0];

  a_r3_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < den_q));
  a_r11_div_finishes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && cnt_q == CW'(1)) |=> (done_q && !busy_q));
endmodule

// File: rtl/ddr3_timing_calc.sv
module ddr3_timing_calc
  import ddr3_calc_pkg::*;
#(
  parameter int RW = 16,
  parameter int TW = 16,
  parameter int W  = 16,
  parameter int DW = 20,
  parameter int BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW-1:0] rate_i,
  input  logic          fam_hi_i,
  input  logic [3:0]    dens_i,
  input  logic          page_i,
  input  logic [TW-1:0] trc_i,
  input  logic [TW-1:0] tras_i,
  input  logic [TW-1:0] trcd_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [2:0]    cwl_o,
  output logic [W-1:0]  clkper_o,
  output logic [W-1:0]  trfc_o,
  output logic [W-1:0]  txs_o,
  output logic [W-1:0]  txp_o,
  output logic [W-1:0]  tcke_o,
  output logic [W-1:0]  tfaw_o,
  output logic [W-1:0]  trrd_o,
  output logic [W-1:0]  txpdll_o,
  output logic [W-1:0]  tcksre_o,
  output logic [W-1:0]  taonpd_o,
  output logic [W-1:0]  twr_o,
  output logic [W-1:0]  tmrd_o,
  output logic [W-1:0]  trc_o,
  output logic [W-1:0]  tras_o,
  output logic [W-1:0]  tcl_o,
  output logic [W-1:0]  trp_o
);
  fsm_e           state_q;
  step_e          step_q;
  logic [W-1:0]   res_q [NSTEP];
  logic [CKW-1:0] clk_q;
  logic           fast_q, page_q, err_q;
  logic [3:0]     dens_q;
  logic [TW-1:0]  trc_q, tras_q, trcd_q;
  logic [2:0]     cwl_q;

  logic [CKW-1:0] clk_w;
  logic [2:0]     cwl_w;
  logic           fast_w, spd_bad_w, bad_w;
  logic [DW-1:0]  num_w;
  logic [BW-1:0]  den_w;
  logic           ceil_w, div_done_w;
  logic [1:0]     sub_w;
  logic [W-1:0]   quot_w;
  logic           idle_w;

  ddr3_clk_sel #(.RW(RW)) u_clk_sel (
    .rate_i(rate_i), .fam_hi_i(fam_hi_i), .clk_mhz_o(clk_w),
    .cwl_o(cwl_w), .fast_o(fast_w), .bad_o(spd_bad_w)
  );

  ddr3_step_gen #(.DW(DW), .BW(BW), .W(W), .TW(TW)) u_step_gen (
    .step_i(step_q), .clk_mhz_i(clk_q), .per_i(res_q[ST_PER]),
    .per10_i(res_q[ST_P10]), .fast_i(fast_q), .page_i(page_q),
    .dens_i(dens_q), .trc_i(trc_q), .tras_i(tras_q), .trcd_i(trcd_q),
    .num_o(num_w), .den_o(den_w), .ceil_o(ceil_w), .sub_o(sub_w)
  );

  ddr3_ceil_div #(.DW(DW), .BW(BW), .QW(W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(state_q == S_ISSUE),
    .ceil_i(ceil_w), .num_i(num_w), .den_i(den_w),
    .done_o(div_done_w), .quot_o(quot_w)
  );

  assign bad_w  = spd_bad_w || !dens_ok(dens_i);
  assign idle_w = (state_q == S_IDLE) || (state_q == S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= ST_PER;
      for (int i = 0; i < NSTEP; i++) res_q[i] <= '0;
      clk_q   <= '0;
      fast_q  <= 1'b0;
      page_q  <= 1'b0;
      err_q   <= 1'b0;
      dens_q  <= '0;
      trc_q   <= '0;
      tras_q  <= '0;
      trcd_q  <= '0;
      cwl_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: begin
          if (start_i) begin
            for (int i = 0; i < NSTEP; i++) res_q[i] <= '0;
            clk_q   <= clk_w;
            fast_q  <= fast_w;
            page_q  <= page_i;
            dens_q  <= dens_i;
            trc_q   <= trc_i;
            tras_q  <= tras_i;
            trcd_q  <= trcd_i;
            err_q   <= bad_w;
            cwl_q   <= bad_w ? 3'd0 : cwl_w;
            step_q  <= ST_PER;
            state_q <= bad_w ? S_DONE : S_ISSUE;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (div_done_w) begin
            res_q[step_q] <= quot_w - W'(sub_w);
            if (step_q == ST_RP) begin
              state_q <= S_DONE;
            end else begin
              step_q  <= step_e'(step_q + 5'd1);
              state_q <= S_ISSUE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = !idle_w;
  assign done_o   = (state_q == S_DONE);
  assign err_o    = err_q;
  assign cwl_o    = cwl_q;
  assign clkper_o = res_q[ST_PER];
  assign trfc_o   = res_q[ST_RFC];
  assign txs_o    = res_q[ST_XS];
  assign txp_o    = res_q[ST_XP];
  assign tcke_o   = res_q[ST_CKE];
  assign tfaw_o   = res_q[ST_FAW];
  assign trrd_o   = res_q[ST_RRD];
  assign txpdll_o = res_q[ST_XPDLL];
  assign tcksre_o = res_q[ST_CKSRE];
  assign taonpd_o = res_q[ST_AONPD];
  assign twr_o    = res_q[ST_WR];
  assign tmrd_o   = res_q[ST_MRD];
  assign trc_o    = res_q[ST_RC];
  assign tras_o   = res_q[ST_RAS];
  assign tcl_o    = res_q[ST_CL];
  assign trp_o    = res_q[ST_RP];

  a_r11_done_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(trfc_o) && $stable(clkper_o) && $stable(err_o)));
  a_r9_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (clkper_o == '0 && trfc_o == '0 && tcl_o == '0 && cwl_o == 3'd0));
  a_r2_cwl_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (cwl_o == 3'(CWL_HI) || cwl_o == 3'(CWL_LO)));
  a_r3_period_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (clkper_o == W'(PS_MHZ / CLK_HI_MAX) || clkper_o == W'(PS_MHZ / (RATE_LO / 2))));
  a_r10_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q == S_ISSUE) |=> (state_q == S_WAIT));
endmodule

// File: tb/ddr3_timing_calc_tb.sv
module ddr3_timing_calc_tb;
  localparam int LAT = 17 * (20 + 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] rate = '0;
  logic        fam = 1'b0;
  logic [3:0]  dens = '0;
  logic        page = 1'b0;
  logic [15:0] trc = '0, tras = '0, trcd = '0;
  logic        busy, done, err;
  logic [2:0]  cwl;
  logic [15:0] act [16];

  int tests = 0;
  int fails = 0;

  ddr3_timing_calc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_i(rate), .fam_hi_i(fam),
    .dens_i(dens), .page_i(page), .trc_i(trc), .tras_i(tras), .trcd_i(trcd),
    .busy_o(busy), .done_o(done), .err_o(err), .cwl_o(cwl),
    .clkper_o(act[0]), .trfc_o(act[1]), .txs_o(act[2]), .txp_o(act[3]),
    .tcke_o(act[4]), .tfaw_o(act[5]), .trrd_o(act[6]), .txpdll_o(act[7]),
    .tcksre_o(act[8]), .taonpd_o(act[9]), .twr_o(act[10]), .tmrd_o(act[11]),
    .trc_o(act[12]), .tras_o(act[13]), .tcl_o(act[14]), .trp_o(act[15])
  );

  string tags [16] = '{"R3 clkper", "R4 trfc", "R4 txs", "R5 txp", "R6 tcke",
    "R6 tfaw", "R6 trrd", "R5 txpdll", "R5 tcksre", "R7 taonpd", "R7 twr",
    "R5 tmrd", "R8 trc", "R8 tras", "R8 tcl", "R8 trp"};

  int e [16];
  int m_err = 0, m_cwl = 0, m_busy = 0, m_done = 0, m_cnt = 0;

  task automatic chk(input string tag, input int a, input int x);
    tests++;
    if (a != x) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, a, x);
    end
  endtask

  function automatic int cd(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic model_calc();
    int r, c, p, p10, rfc, q;
    bit fast, bad;
    r = fam ? ((rate > 1066) ? 1066 : int'(rate)) : ((rate > 800) ? 800 : int'(rate));
    fast = (r == 1066);
    case (dens)
      4'd1: rfc = 110000;
      4'd2: rfc = 160000;
      4'd4: rfc = 260000;
      4'd8: rfc = 350000;
      default: rfc = 0;
    endcase
    bad = !(r == 800 || r == 1066) || (rfc == 0);
    m_err = bad;
    if (bad) begin
      m_cwl = 0;
      for (int i = 0; i < 16; i++) e[i] = 0;
    end else begin
      m_cwl = fam ? 4 : 3;
      c = r / 2;
      if (fam && c > 528) c = 528;
      p = 1000000 / c;
      p10 = p / 10;
      e[0]  = p;
      e[1]  = cd(rfc, p) - 1;
      e[2]  = cd(rfc + 10000, p) - 1;
      e[3]  = cd(mx(3 * p, 7500), p) - 1;
      e[4]  = cd(mx(3 * p, fast ? 5625 : 7500), p) - 1;
      e[5]  = cd(page ? (fast ? 37500 : 40000) : 50000, p) - 1;
      e[6]  = cd(mx(4 * p, (fast && page) ? 7500 : 10000), p) - 1;
      e[7]  = cd(mx(10 * p, 24000), p) - 1;
      e[8]  = cd(mx(5 * p, 10000), p);
      e[9]  = cd(2000, p) - 1;
      e[10] = cd(15000, p) - 1;
      e[11] = cd(mx(12 * p, 15000), p) - 1;
      e[12] = cd(int'(trc), p10) - 1;
      e[13] = cd(int'(tras), p10) - 1;
      q = cd(int'(trcd), p10);
      e[14] = (q - 3) & 16'hFFFF;
      e[15] = (q - 1) & 16'hFFFF;
    end
  endtask

  // reference timing model, advanced at each active edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cwl = 0; m_cnt = 0;
      for (int i = 0; i < 16; i++) e[i] = 0;
    end else if (m_busy != 0) begin
      m_cnt--;
      if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
    end else if (start) begin
      model_calc();
      if (m_err != 0) m_done = 1;
      else begin m_busy = 1; m_done = 0; m_cnt = LAT; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 done", int'(done), m_done);
      chk("R11 busy", int'(busy), m_busy);
      if (m_done != 0) begin
        chk("R9 err", int'(err), m_err);
        chk("R2 cwl", int'(cwl), m_cwl);
        for (int i = 0; i < 16; i++) chk(tags[i], int'(act[i]), e[i]);
      end
    end
  end

  task automatic run(input int r, input bit f, input int d, input bit pg,
                     input int rc, input int ras, input int rcd);
    int w;
    @(negedge clk);
    rate = 16'(r); fam = f; dens = 4'(d); page = pg;
    trc = 16'(rc); tras = 16'(ras); trcd = 16'(rcd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 2000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: actual no finish expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 err in reset", int'(err), 0);
    chk("R1 clkper in reset", int'(act[0]), 0);
    chk("R1 cwl in reset", int'(cwl), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'(done), 0);

    run(1066, 1, 4, 1, 4875, 3500, 1375);
    run(1600, 1, 8, 0, 4875, 3500, 1375);  // capped, clock limited to 528
    run(800,  1, 1, 1, 5000, 3750, 1500);
    run(1066, 0, 2, 1, 5000, 3750, 1500);  // standard family capped to 800
    run(800,  0, 8, 0, 5250, 3750, 1375);
    run(1066, 1, 2, 0, 5063, 3750, 1313);
    run(1066, 1, 3, 1, 4875, 3500, 1375);  // bad density
    chk("R9 err on density", int'(err), 1);
    chk("R9 trfc zero on error", int'(act[1]), 0);
    run(933,  1, 4, 1, 4875, 3500, 1375);  // bad high-end rate
    chk("R9 err on high-end rate", int'(err), 1);
    run(667,  0, 4, 1, 4875, 3500, 1375);  // bad standard rate
    chk("R9 err on standard rate", int'(err), 1);
    run(800,  0, 4, 1, 5000, 3750, 1500);  // recovery after error
    chk("R9 err cleared", int'(err), 0);

    // start while busy: second pulse with other inputs must be ignored
    @(negedge clk);
    rate = 16'd1066; fam = 1'b1; dens = 4'd8; page = 1'b0;
    trc = 16'd4875; tras = 16'd3500; trcd = 16'd1375;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rate = 16'd800; fam = 1'b0; dens = 4'd1; page = 1'b1; trcd = 16'd3000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R10 busy start ignored trfc", int'(act[1]), e[1]);
    chk("R10 busy start ignored cwl", int'(cwl), 4);
    chk("R10 busy start ignored clkper", int'(act[0]), 1893);

    // inputs change while done and no start: outputs hold
    rate = 16'd900; dens = 4'd3; trc = 16'd100; trcd = 16'd100;
    repeat (10) @(negedge clk);
    chk("R10 hold done", int'(done), 1);
    chk("R10 hold trfc", int'(act[1]), e[1]);
    chk("R10 hold tcl", int'(act[14]), e[14]);
    chk("R10 hold err", int'(err), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule